// File: doc/BRIEF.md
# Double-Buffered Coefficient Memory Switch

This block stores the coefficients of a running digital filter in two equal byte banks so that new values can be loaded while audio keeps flowing. The filter datapath reads whole coefficient words combinationally from whichever bank is currently live. The host loads bytes through a single address window. In adaptive operation that window always lands in the bank the filter is not using, so a half-written set never reaches the filter.

The host commits a staged set by setting a switch bit in a small control byte. The swap takes place on the first sample strobe that follows the request, which is the point where the filter takes one complete coefficient set. The bit then clears, and the host polls it to learn that the swap is done. The host then writes the same values again so that both banks match. With adaptive operation off, the filter and the host window both stay on bank A and the second bank plays no part.

Top module: `coef_dbuf_top`

## Requirements
- R1: After reset, bank A is live, the control readback is 0x00, `live_bank` is 0, and every coefficient the filter reads is zero.
- R2: A control write takes bit 2 as the adaptive-enable bit and bit 0 as the switch request. The readback carries the adaptive bit at bit 2 and the pending switch flag at bit 0, and all other bits read 0.
- R3: While adaptive operation is off, host writes go to bank A and the filter reads bank A. A switch request is ignored: bit 0 reads 0 and no strobe changes the live bank.
- R4: While adaptive operation is on, a host byte write goes to the bank that is not live. The filter output does not change until a swap makes that bank live.
- R5: An accepted request makes bit 0 read 1 from the next cycle. The first sample strobe seen with the flag set swaps the live bank at that edge and clears the flag. A request made in the same cycle as a strobe waits for the next strobe.
- R6: A switch request written while one is already pending has no effect. It causes exactly one swap, and a later strobe with no new request swaps nothing.
- R7: Coefficient k occupies host bytes k*COEF_BYTES to k*COEF_BYTES+COEF_BYTES-1, and the lowest address holds the most significant byte. Writes at addresses beyond the last coefficient byte are dropped. Reads of an index at or beyond NUM_COEF return zero.
- R8: Writing the control byte with bit 2 clear cancels any pending request and makes bank A live again.
- R9: The filter read port returns the addressed word of the live bank in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte: bit 2 adaptive enable, bit 0 switch request |
| ctrl_rdata | output | 8 | Control readback: bit 2 adaptive, bit 0 switch pending |
| cw_we | input | 1 | Host coefficient byte write strobe |
| cw_addr | input | AW | Host byte address in the coefficient window |
| cw_wdata | input | 8 | Host coefficient byte |
| sample_stb | input | 1 | One-cycle sample boundary strobe from the filter |
| filt_idx | input | IW | Coefficient index requested by the filter |
| filt_coef | output | 8*COEF_BYTES | Coefficient word from the live bank |
| live_bank | output | 1 | Bank the filter reads (0 = A, 1 = B) |

## Verification
The bench builds the block with its defaults: ten coefficients of two bytes, which is two biquads, with a five-bit byte address and a four-bit index. These values leave twelve addresses above the last coefficient byte and six indices above the last coefficient, so the dropped writes and the zero reads can both be reached. Two-byte words expose the byte order, and the small bank lets every word of both banks be compared against the model after every clock.

// File: rtl/coef_dbuf_pkg.sv
package coef_dbuf_pkg;
  localparam int CTRL_SWITCH_BIT = 0;
  localparam int CTRL_ADAPT_BIT  = 2;

  // Bank the host window lands in: the idle bank when adaptive, else A.
  function automatic logic host_bank(input logic adaptive, input logic live);
    return adaptive ? ~live : 1'b0;
  endfunction

  // Bank the filter reads: the live bank when adaptive, else A.
  function automatic logic read_bank(input logic adaptive, input logic live);
    return adaptive ? live : 1'b0;
  endfunction
endpackage

// File: rtl/coef_dbuf_bank.sv
module coef_dbuf_bank #(
  parameter int NUM_COEF   = 10,
  parameter int COEF_BYTES = 2,
  parameter int AW         = 5,
  parameter int IW         = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [7:0]              wdata,
  input  logic [IW-1:0]           rd_idx,
  output logic [8*COEF_BYTES-1:0] rd_word
);
  localparam int NB = NUM_COEF * COEF_BYTES;
  localparam logic [AW:0] NB_L = (AW+1)'(NB);
  localparam logic [IW:0] NC_L = (IW+1)'(NUM_COEF);

  logic [7:0] mem [NB];
  logic       addr_ok;
  logic       idx_ok;

  assign addr_ok = ({1'b0, addr} < NB_L);
  assign idx_ok  = ({1'b0, rd_idx} < NC_L);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= '0;
    end else if (we && addr_ok) begin
      mem[addr] <= wdata;
    end
  end

  // Lowest byte address holds the most significant byte.
  always_comb begin
    rd_word = '0;
    if (idx_ok) begin
      for (int b = 0; b < COEF_BYTES; b++)
        rd_word[(COEF_BYTES-1-b)*8 +: 8] = mem[AW'(int'(rd_idx)*COEF_BYTES + b)];
    end
  end
endmodule

// File: rtl/coef_dbuf_swap.sv
module coef_dbuf_swap
  import coef_dbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       sample_stb,
  output logic       adaptive,
  output logic       pending,
  output logic       live,
  output logic       swap_evt,
  output logic       cancel_evt
);
  logic req_ok;

  assign cancel_evt = ctrl_we && !ctrl_wdata[CTRL_ADAPT_BIT];
  assign swap_evt   = pending && sample_stb && !cancel_evt;
  assign req_ok     = ctrl_we && ctrl_wdata[CTRL_SWITCH_BIT]
                      && ctrl_wdata[CTRL_ADAPT_BIT] && !pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adaptive <= 1'b0;
      pending  <= 1'b0;
      live     <= 1'b0;
    end else begin
      if (ctrl_we) adaptive <= ctrl_wdata[CTRL_ADAPT_BIT];
      if (cancel_evt) begin
        pending <= 1'b0;
        live    <= 1'b0;
      end else if (swap_evt) begin
        pending <= 1'b0;
        live    <= ~live;
      end else if (req_ok) begin
        pending <= 1'b1;
      end
    end
  end

  // R5: the live bank moves only on a strobe with a pending flag, or on a cancel (R8)
  a_r5_swap_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (live != $past(live)) |-> ($past(sample_stb && pending) || $past(ctrl_we && !ctrl_wdata[CTRL_ADAPT_BIT])));

  // R5: a strobe with a pending flag clears it at the next edge
  a_r5_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && sample_stb) |=> !pending);

  // R6: a repeated request while pending, without a strobe, changes nothing
  a_r6_repeat_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !sample_stb && ctrl_we && ctrl_wdata[CTRL_SWITCH_BIT] && ctrl_wdata[CTRL_ADAPT_BIT])
    |=> (pending && $stable(live)));

  // R3 / R8: outside adaptive operation no flag is held and bank A is live
  a_r3_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !adaptive |-> (!pending && !live));
endmodule

// File: rtl/coef_dbuf_top.sv
module coef_dbuf_top
  import coef_dbuf_pkg::*;
#(
  parameter int NUM_COEF   = 10,
  parameter int COEF_BYTES = 2,
  localparam int NB        = NUM_COEF * COEF_BYTES,
  localparam int AW        = $clog2(NB),
  localparam int IW        = $clog2(NUM_COEF),
  localparam int CW        = 8 * COEF_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [7:0]    ctrl_wdata,
  output logic [7:0]    ctrl_rdata,
  input  logic          cw_we,
  input  logic [AW-1:0] cw_addr,
  input  logic [7:0]    cw_wdata,
  input  logic          sample_stb,
  input  logic [IW-1:0] filt_idx,
  output logic [CW-1:0] filt_coef,
  output logic          live_bank
);
  logic          adaptive, pending, live, swap_evt, cancel_evt;
  logic          wr_bank;
  logic [1:0]    bank_we;
  logic [CW-1:0] bank_word [2];
  logic          unused_ctrl_bits;

  assign unused_ctrl_bits = ^{ctrl_wdata[7:3], ctrl_wdata[1]};

  coef_dbuf_swap u_swap (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .sample_stb (sample_stb),
    .adaptive   (adaptive),
    .pending    (pending),
    .live       (live),
    .swap_evt   (swap_evt),
    .cancel_evt (cancel_evt)
  );

  assign wr_bank   = host_bank(adaptive, live);
  assign live_bank = read_bank(adaptive, live);

  for (genvar g = 0; g < 2; g++) begin : g_bank
    assign bank_we[g] = cw_we && (wr_bank == 1'(g));
    coef_dbuf_bank #(
      .NUM_COEF   (NUM_COEF),
      .COEF_BYTES (COEF_BYTES),
      .AW         (AW),
      .IW         (IW)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bank_we[g]),
      .addr    (cw_addr),
      .wdata   (cw_wdata),
      .rd_idx  (filt_idx),
      .rd_word (bank_word[g])
    );
  end

  assign filt_coef  = bank_word[live_bank];
  assign ctrl_rdata = {5'b0, adaptive, 1'b0, pending};

  // R4: in adaptive operation the host never writes the bank the filter reads
  a_r4_write_idle_bank: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_we[0] && !live_bank) || (bank_we[1] && live_bank)) |-> !adaptive);

  // R3: outside adaptive operation bank B is neither written nor read
  a_r3_bank_b_unused: assert property (@(posedge clk) disable iff (!rst_n)
    !adaptive |-> (!bank_we[1] && !live_bank));

  // R5: the readback flag and the swap event agree
  a_r5_swap_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |-> (ctrl_rdata[0] && sample_stb));

  // R8: a cancel leaves bank A live and nothing pending
  a_r8_cancel_result: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt |=> (!live_bank && !ctrl_rdata[0]));
endmodule

// File: tb/coef_dbuf_top_tb_top.sv
`timescale 1ns/1ps
module coef_dbuf_top_tb_top;
  localparam int NC = 10;
  localparam int CB = 2;
  localparam int NBYTES = NC * CB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [7:0]  ctrl_rdata;
  logic        cw_we = 1'b0;
  logic [4:0]  cw_addr = '0;
  logic [7:0]  cw_wdata = '0;
  logic        sample_stb = 1'b0;
  logic [3:0]  filt_idx = '0;
  logic [15:0] filt_coef;
  logic        live_bank;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int ref_a [NBYTES];
  int ref_b [NBYTES];
  bit m_adapt, m_pend, m_live;

  always #4 clk = ~clk;

  coef_dbuf_top dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .cw_we(cw_we), .cw_addr(cw_addr), .cw_wdata(cw_wdata),
    .sample_stb(sample_stb), .filt_idx(filt_idx), .filt_coef(filt_coef),
    .live_bank(live_bank)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expected_word(int idx);
    int hi, lo;
    bit b;
    if (idx >= NC) return 0;
    b = m_adapt && m_live;
    hi = b ? ref_b[idx*CB] : ref_a[idx*CB];
    lo = b ? ref_b[idx*CB+1] : ref_a[idx*CB+1];
    return hi * 256 + lo;
  endfunction

  task automatic compare_all(string tag);
    check({tag, " ctrl readback"}, int'(ctrl_rdata),
          (m_adapt ? 4 : 0) + (m_pend ? 1 : 0));
    check({tag, " live bank"}, int'(live_bank), (m_adapt && m_live) ? 1 : 0);
    for (int i = 0; i < 16; i++) begin
      filt_idx = 4'(i);
      #0.5;
      check({tag, " R9 coef word"}, int'(filt_coef), expected_word(i));
    end
  endtask

  // applies the given inputs for one clock, updates the model, compares
  task automatic cyc(string tag, bit cwe, int cwd, bit hwe, int ha, int hd, bit stb);
    bit tgt_b;
    ctrl_we = cwe; ctrl_wdata = 8'(cwd);
    cw_we = hwe; cw_addr = 5'(ha); cw_wdata = 8'(hd);
    sample_stb = stb;
    @(posedge clk);
    tgt_b = m_adapt && !m_live;
    if (hwe && ha < NBYTES) begin
      if (tgt_b) ref_b[ha] = hd; else ref_a[ha] = hd;
    end
    if (cwe && ((cwd & 4) == 0)) begin
      m_pend = 0; m_live = 0;
    end else if (m_pend && stb) begin
      m_pend = 0; m_live = !m_live;
    end else if (cwe && !m_pend && (cwd & 1) != 0) begin
      m_pend = 1;
    end
    if (cwe) m_adapt = (cwd & 4) != 0;
    @(negedge clk);
    ctrl_we = 0; cw_we = 0; sample_stb = 0;
    compare_all(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int k = 0; k < n; k++) cyc(tag, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lfsr;
    for (int i = 0; i < NBYTES; i++) begin ref_a[i] = 0; ref_b[i] = 0; end
    m_adapt = 0; m_pend = 0; m_live = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare_all("R1");

    // R3: non-adaptive writes land in A, switch ignored
    cyc("R3", 0, 0, 1, 0, 8'h12, 0);
    cyc("R3", 0, 0, 1, 1, 8'h34, 0);
    cyc("R3", 0, 0, 1, 19, 8'h9c, 0);
    cyc("R3", 1, 8'h01, 0, 0, 0, 0);
    check("R3 switch bit ignored", int'(ctrl_rdata[0]), 0);
    cyc("R3", 0, 0, 0, 0, 0, 1);
    check("R3 bank stays A", int'(live_bank), 0);

    // R7: layout and dropped addresses
    cyc("R7", 0, 0, 1, 5, 8'h77, 0);
    for (int a = NBYTES; a < 32; a++) cyc("R7", 0, 0, 1, a, 8'hee, 0);
    filt_idx = 4'd2; #0.5;
    check("R7 low byte at odd address", int'(filt_coef), 16'h0077);
    filt_idx = 4'd12; #0.5;
    check("R7 index beyond range", int'(filt_coef), 0);

    // R2 / R4: enable adaptive, stage into B
    cyc("R2", 1, 8'hfc, 0, 0, 0, 0);
    check("R2 readback masks other bits", int'(ctrl_rdata), 8'h04);
    cyc("R4", 0, 0, 1, 0, 8'haa, 0);
    cyc("R4", 0, 0, 1, 1, 8'hbb, 1);
    filt_idx = 4'd0; #0.5;
    check("R4 staged bytes not visible", int'(filt_coef), 16'h1234);

    // R5: request, hold, swap on strobe
    cyc("R5", 1, 8'h05, 0, 0, 0, 0);
    check("R5 flag set", int'(ctrl_rdata[0]), 1);
    idle("R5", 3);
    cyc("R5", 0, 0, 0, 0, 0, 1);
    check("R5 swapped", int'(live_bank), 1);
    check("R5 flag cleared", int'(ctrl_rdata[0]), 0);
    filt_idx = 4'd0; #0.5;
    check("R4 new set visible", int'(filt_coef), 16'haabb);
    cyc("R4", 0, 0, 1, 0, 8'haa, 0);
    cyc("R4", 0, 0, 1, 1, 8'hbb, 0);

    // R6: repeated request while pending
    cyc("R6", 1, 8'h05, 0, 0, 0, 0);
    cyc("R6", 1, 8'h05, 0, 0, 0, 0);
    cyc("R6", 1, 8'h05, 0, 0, 0, 1);
    check("R6 single swap", int'(live_bank), 0);
    cyc("R6", 0, 0, 0, 0, 0, 1);
    check("R6 no second swap", int'(live_bank), 0);

    // R5: request coinciding with strobe waits
    cyc("R5", 1, 8'h05, 0, 0, 0, 1);
    check("R5 same-cycle strobe no swap", int'(live_bank), 0);
    cyc("R5", 0, 0, 0, 0, 0, 1);
    check("R5 next strobe swaps", int'(live_bank), 1);

    // R8: cancel while pending with B live
    cyc("R8", 1, 8'h05, 0, 0, 0, 0);
    cyc("R8", 1, 8'h00, 0, 0, 0, 0);
    check("R8 cancel flag", int'(ctrl_rdata), 0);
    check("R8 bank A live", int'(live_bank), 0);
    cyc("R8", 0, 0, 0, 0, 0, 1);

    // mixed stimulus
    lfsr = 32'h1ace;
    for (int k = 0; k < 400; k++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13)) & 1);
      lfsr = lfsr & 16'hffff;
      cyc("R4", (lfsr & 7) == 0, ((lfsr >> 3) & 1) ? 5 : ((lfsr >> 4) & 5),
          (lfsr >> 6) & 1, (lfsr >> 7) & 31, (lfsr >> 2) & 255, (lfsr >> 12) & 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule